// File: doc/BRIEF.md
# Carrier Modulator Output Timer

This block generates a single output waveform for infrared-style carrier transmission. An 8-bit down-counter is paired with an 8-bit reload register. A 3-bit mode code selects one of three behaviours: stopped, free-running square wave, or gated pulse. In square-wave mode the counter advances on each instruction-cycle tick. Each time the counter wraps, it reloads and the output toggles. This gives a 50% duty waveform whose half-period is set by the reload value.

In gated mode a strobe from an external 16-bit timer starts a high pulse. The pulse lasts a programmable number of ticks, up to 256. The external timer therefore sets the repetition rate, and the reload value sets the on-time.

Software writes the mode code and the reload value through two strobed write ports. Every mode write restarts the counter from the reload register. A reload write alone only takes effect when the counter next reloads.

Top module: `modout_timer`

## Requirements
- R1: Reset (synchronous, active low) drives the output low, selects the stopped mode and clears the reload register to zero; this also holds when reset arrives while a waveform is running.
- R2: With mode code 3'b001 (bit 0 = square enable), the output starts low and toggles after every reload+1 tick cycles, giving equal high and low phases.
- R3: The counter moves only in cycles where `tick` is high; with `tick` low the output holds its value.
- R4: A mode write loads the counter from the reload register and forces the output low after that clock edge, whatever `tick` does in the same cycle.
- R5: A reload write does not change the phase in progress; the new value is first used at the next reload.
- R6: Mode code 3'b000 keeps the output low and ignores `tick` and `t16_uflow`; the counter is frozen.
- R7: Every mode code other than 3'b001 and 3'b010 behaves as the stopped mode.
- R8: With mode code 3'b010 (bit 1 = gated enable), a `t16_uflow` strobe drives the output high. The output stays high for reload+1 ticks, then stays low until the next strobe.
- R9: In gated mode, a strobe that arrives while the output is high restarts a full high phase.
- R10: A reload value of 255 gives a high phase of 256 ticks in gated mode.
- R11: In square-wave mode `t16_uflow` has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Instruction-cycle enable for the counter |
| t16_uflow | input | 1 | Underflow strobe from the external 16-bit timer |
| mode_we | input | 1 | Mode write strobe |
| mode_wdata | input | 3 | Mode code to write |
| reload_we | input | 1 | Reload register write strobe |
| reload_wdata | input | 8 | Reload value to write |
| mod_out | output | 1 | Modulated output waveform |

## Verification
Square-wave mode is exercised four ways:
- a continuous tick with reload values 0 and 3, which separates the half-period length from an off-by-one;
- a tick on only one cycle in three, which shows the counter follows the enable rather than the clock;
- strobes from the external timer mixed in, which must leave the waveform untouched;
- a reload write made mid-phase, which tells a deferred update apart from an immediate one.

Gated mode is driven with:
- isolated strobes and sparse ticks, which measure the on-time;
- a retriggering strobe, which must restart the on-time;
- a maximum reload of 255, which must give 256 ticks.

All undefined mode codes and a mid-run reset are also applied. Each of these must leave the output low.

// File: rtl/modout_pkg.sv
// Shared definitions for the carrier modulator output timer.
// Assumes a 3-bit mode code where bit 0 selects the square wave and
// bit 1 selects the gated pulse; every other code stops the block.
package modout_pkg;

    localparam int MODE_BITS = 3;

    typedef enum logic [1:0] {
        MODE_IDLE   = 2'd0,
        MODE_SQUARE = 2'd1,
        MODE_GATED  = 2'd2
    } modout_mode_e;

    // Map a raw mode code onto the operating mode.
    function automatic modout_mode_e decode_mode(input logic [MODE_BITS-1:0] code);
        case (code)
            3'b001:  return MODE_SQUARE;
            3'b010:  return MODE_GATED;
            default: return MODE_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/modout_regs.sv
// Software-visible state: the decoded mode and the reload value.
// Assumes write strobes last one cycle. A mode write produces a one-cycle
// restart pulse in the same cycle, for the counter and the output stage.
module modout_regs
    import modout_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mode_we,
    input  logic [MODE_BITS-1:0] mode_wdata,
    input  logic                 reload_we,
    input  logic [CNT_W-1:0]     reload_wdata,
    output modout_mode_e         mode_q,
    output logic [CNT_W-1:0]     reload_q,
    output logic                 restart
);

    // Hold the decoded mode; reset selects the stopped mode.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= MODE_IDLE;
        else if (mode_we) mode_q <= decode_mode(mode_wdata);
    end

    // Hold the reload value; the counter reads it only when it reloads.
    always_ff @(posedge clk) begin
        if (!rst_n)         reload_q <= '0;
        else if (reload_we) reload_q <= reload_wdata;
    end

    // Any mode write restarts the waveform.
    assign restart = mode_we;

endmodule

// File: rtl/modout_counter.sv
// Down-counter with parallel load. It stops at zero unless it is reloaded.
// Assumes load has priority over decrement.
module modout_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             dec,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             at_zero
);

    // Load, count down, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)                     cnt_q <= '0;
        else if (load)                  cnt_q <= load_val;
        else if (dec && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    // Flag the terminal count for the control logic.
    assign at_zero = (cnt_q == '0);

endmodule

// File: rtl/modout_shaper.sv
// Output flop with clear, set and toggle controls, in that priority.
// Assumes the controls are already qualified by the mode.
module modout_shaper (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic set,
    input  logic toggle,
    output logic out_q
);

    // Update the output level from the prioritised controls.
    always_ff @(posedge clk) begin
        if (!rst_n)      out_q <= 1'b0;
        else if (clr)    out_q <= 1'b0;
        else if (set)    out_q <= 1'b1;
        else if (toggle) out_q <= ~out_q;
    end

endmodule

// File: rtl/modout_timer.sv
// Carrier modulator output timer (top).
// Square mode: toggles the output each time the counter wraps on a tick.
// Gated mode: a strobe from the external 16-bit timer starts a high
// pulse lasting reload+1 ticks.
// Assumes tick and t16_uflow are synchronous single-cycle enables.
module modout_timer
    import modout_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 t16_uflow,
    input  logic                 mode_we,
    input  logic [MODE_BITS-1:0] mode_wdata,
    input  logic                 reload_we,
    input  logic [CNT_W-1:0]     reload_wdata,
    output logic                 mod_out
);

    modout_mode_e     mode_cur;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] cnt_q;
    logic             restart;
    logic             at_zero;
    logic             out_q;
    logic             sq_run, gt_run;
    logic             sq_wrap, gt_fire, gt_end;
    logic             cnt_load, cnt_dec;
    logic             sh_clr, sh_set, sh_tgl;

    modout_regs #(.CNT_W(CNT_W)) i_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_we      (mode_we),
        .mode_wdata   (mode_wdata),
        .reload_we    (reload_we),
        .reload_wdata (reload_wdata),
        .mode_q       (mode_cur),
        .reload_q     (reload_q),
        .restart      (restart)
    );

    // Qualify the counter and output controls by the current mode.
    always_comb begin
        sq_run   = (mode_cur == MODE_SQUARE);
        gt_run   = (mode_cur == MODE_GATED);
        sq_wrap  = sq_run && tick && at_zero;
        gt_fire  = gt_run && t16_uflow;
        gt_end   = gt_run && tick && at_zero && out_q && !t16_uflow;
        cnt_load = restart || sq_wrap || gt_fire;
        cnt_dec  = tick && (sq_run || (gt_run && out_q));
        sh_clr   = restart || (mode_cur == MODE_IDLE) || gt_end;
        sh_set   = gt_fire && !restart;
        sh_tgl   = sq_wrap && !restart;
    end

    modout_counter #(.CNT_W(CNT_W)) i_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .dec      (cnt_dec),
        .load_val (reload_q),
        .cnt_q    (cnt_q),
        .at_zero  (at_zero)
    );

    modout_shaper i_shaper (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (sh_clr),
        .set    (sh_set),
        .toggle (sh_tgl),
        .out_q  (out_q)
    );

    assign mod_out = out_q;

endmodule

// File: rtl/modout_checker.sv
// Temporal checks on the modulator output timer, bound to the top module.
module modout_checker
    import modout_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             t16_uflow,
    input logic             mode_we,
    input logic             reload_we,
    input modout_mode_e     mode_cur,
    input logic [CNT_W-1:0] cnt,
    input logic             mod_out
);

    assert_restart_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mode_we |=> !mod_out);

    assert_idle_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_cur == MODE_IDLE && !mode_we) |=> !mod_out);

    assert_hold_no_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_cur == MODE_SQUARE && !tick && !mode_we) |=> $stable(mod_out));

    assert_toggle_on_wrap_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_cur == MODE_SQUARE && tick && cnt != '0 && !mode_we) |=> $stable(mod_out));

    assert_strobe_sets_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_cur == MODE_GATED && t16_uflow && !mode_we) |=> mod_out);

    assert_reload_deferred_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_we && !mode_we && !tick && !t16_uflow) |=> $stable(cnt));

endmodule

bind modout_timer modout_checker #(.CNT_W(CNT_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .t16_uflow (t16_uflow),
    .mode_we   (mode_we),
    .reload_we (reload_we),
    .mode_cur  (mode_cur),
    .cnt       (cnt_q),
    .mod_out   (mod_out)
);

// File: tb/test_modout_timer.sv
// Scoreboard bench: driver tasks queue the expected output for each cycle,
// and a monitor pops and compares after every rising edge.
module test_modout_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       t16_uflow = 1'b0;
    logic       mode_we = 1'b0;
    logic [2:0] mode_wdata = 3'b000;
    logic       reload_we = 1'b0;
    logic [7:0] reload_wdata = 8'd0;
    logic       mod_out;

    logic  exp_q[$];
    string tag_q[$];
    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;

    always #5 clk = ~clk;

    modout_timer #(.CNT_W(8)) i_modout_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .t16_uflow    (t16_uflow),
        .mode_we      (mode_we),
        .mode_wdata   (mode_wdata),
        .reload_we    (reload_we),
        .reload_wdata (reload_wdata),
        .mod_out      (mod_out)
    );

    // Drive one cycle of inputs and queue the output expected after its edge.
    task automatic cyc(input logic rn, input logic tk, input logic uf, input logic mwe,
                       input logic [2:0] md, input logic rwe, input logic [7:0] rd,
                       input logic ev, input string tag);
        @(negedge clk);
        rst_n = rn; tick = tk; t16_uflow = uf; mode_we = mwe;
        mode_wdata = md; reload_we = rwe; reload_wdata = rd;
        exp_q.push_back(ev);
        tag_q.push_back(tag);
    endtask

    task automatic step(input logic tk, input logic uf, input logic ev, input string tag);
        cyc(1'b1, tk, uf, 1'b0, 3'b000, 1'b0, 8'd0, ev, tag);
    endtask

    task automatic wr_mode(input logic [2:0] md, input logic tk, input logic ev, input string tag);
        cyc(1'b1, tk, 1'b0, 1'b1, md, 1'b0, 8'd0, ev, tag);
    endtask

    task automatic wr_reload(input logic [7:0] rd, input logic ev, input string tag);
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 3'b000, 1'b1, rd, ev, tag);
    endtask

    // Monitor: compare after every rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                logic  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                total++;
                if (mod_out !== e) begin
                    bad++;
                    $display("FAIL %s: mod_out=%b expected %b at %0t", t, mod_out, e, $time);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        // R1: reset state, output low and stopped mode ignores inputs
        for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1, 1'b1, 1'b0, 3'b000, 1'b0, 8'd0, 1'b0, "R1");
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b0, "R1");
        // R1: reload resets to zero, so square mode toggles on every tick
        wr_mode(3'b001, 1'b0, 1'b0, "R1");
        for (int i = 1; i <= 6; i++) step(1'b1, 1'b0, (i % 2) == 1, "R1");

        // R2: square wave, reload 3, continuous tick
        wr_reload(8'd3, 1'b0, "R3");
        wr_mode(3'b001, 1'b0, 1'b0, "R4");
        n = 0;
        for (int i = 0; i < 40; i++) begin n++; step(1'b1, 1'b0, ((n / 4) % 2) == 1, "R2"); end

        // R3: tick on one cycle in three
        wr_reload(8'd2, 1'b0, "R3");
        wr_mode(3'b001, 1'b0, 1'b0, "R4");
        n = 0;
        for (int i = 0; i < 45; i++) begin
            logic tk;
            tk = (i % 3) == 2;
            if (tk) n++;
            step(tk, 1'b0, ((n / 3) % 2) == 1, "R3");
        end

        // R11: strobes from the 16-bit timer ignored in square mode
        wr_mode(3'b001, 1'b0, 1'b0, "R4");
        n = 0;
        for (int i = 0; i < 30; i++) begin n++; step(1'b1, (i % 4) == 1, ((n / 3) % 2) == 1, "R11"); end

        // R4: restart while output high, with tick in the same cycle
        for (int i = 0; i < 3; i++) begin n++; step(1'b1, 1'b0, ((n / 3) % 2) == 1, "R4"); end
        wr_mode(3'b001, 1'b1, 1'b0, "R4");
        n = 0;
        for (int i = 0; i < 10; i++) begin n++; step(1'b1, 1'b0, ((n / 3) % 2) == 1, "R4"); end

        // R5: reload changed mid-phase applies only at the next reload
        wr_reload(8'd4, 1'b1, "R5");
        wr_mode(3'b001, 1'b0, 1'b0, "R5");
        n = 0;
        for (int i = 0; i < 20; i++) begin
            logic ev;
            n++;
            if (n < 5) ev = 1'b0;
            else       ev = (((n - 5) / 2) % 2) == 0;
            if (n == 2) cyc(1'b1, 1'b1, 1'b0, 1'b0, 3'b000, 1'b1, 8'd1, ev, "R5");
            else        step(1'b1, 1'b0, ev, "R5");
        end

        // R6: stopped mode
        wr_mode(3'b000, 1'b1, 1'b0, "R6");
        for (int i = 0; i < 10; i++) step(1'b1, (i % 2) == 1, 1'b0, "R6");

        // R7: undefined codes behave as stopped
        for (int k = 3; k < 8; k++) begin
            wr_reload(8'd0, 1'b0, "R7");
            wr_mode(3'(k), 1'b1, 1'b0, "R7");
            for (int i = 0; i < 6; i++) step(1'b1, 1'b1, 1'b0, "R7");
        end

        // R8: gated mode, reload 3
        wr_reload(8'd3, 1'b0, "R8");
        wr_mode(3'b010, 1'b0, 1'b0, "R8");
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0, "R8");
        step(1'b1, 1'b1, 1'b1, "R8");
        n = 0;
        for (int i = 0; i < 8; i++) begin n++; step(1'b1, 1'b0, n < 4, "R8"); end
        // R8: on-time counted in ticks, not clocks
        step(1'b0, 1'b1, 1'b1, "R8");
        n = 0;
        for (int i = 0; i < 12; i++) begin
            logic tk;
            tk = (i % 2) == 1;
            if (tk) n++;
            step(tk, 1'b0, n < 4, "R8");
        end

        // R9: retrigger during the high phase
        step(1'b1, 1'b1, 1'b1, "R9");
        step(1'b1, 1'b0, 1'b1, "R9");
        step(1'b1, 1'b0, 1'b1, "R9");
        step(1'b1, 1'b1, 1'b1, "R9");
        n = 0;
        for (int i = 0; i < 6; i++) begin n++; step(1'b1, 1'b0, n < 4, "R9"); end

        // R10: maximum on-time of 256 ticks
        wr_reload(8'd255, 1'b0, "R10");
        step(1'b0, 1'b1, 1'b1, "R10");
        n = 0;
        for (int i = 0; i < 260; i++) begin n++; step(1'b1, 1'b0, n < 256, "R10"); end

        // R1: reset while a square wave is high
        wr_reload(8'd1, 1'b0, "R1");
        wr_mode(3'b001, 1'b0, 1'b0, "R4");
        step(1'b1, 1'b0, 1'b0, "R2");
        step(1'b1, 1'b0, 1'b1, "R2");
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 3'b000, 1'b0, 8'd0, 1'b0, "R1");
        for (int i = 0; i < 5; i++) step(1'b1, 1'b1, 1'b0, "R1");
        wr_mode(3'b001, 1'b0, 1'b0, "R1");
        step(1'b1, 1'b0, 1'b1, "R1");
        step(1'b1, 1'b0, 1'b0, "R1");

        step(1'b0, 1'b0, 1'b0, "R3");
        repeat (3) @(posedge clk);
        #3;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule